// File: doc/BRIEF.md
# Buffered Auto-Reload Down Counter Channel

This block is a single down-counting timer channel. Software writes a count buffer and a compare buffer. A shared control register holds a four-bit field for each channel: start, manual update, output invert and auto-reload. The channel takes the whole control-register write, picks out its own field and detects edges on it. A rising manual-update bit copies both buffers into the live counter and the active compare value. A rising start bit lets the counter run, and a falling start bit halts it.

While the channel runs, each tick-enable strobe from the prescaler lowers the count by one. A tick that arrives while the count is zero is an expiry. On expiry the channel raises a one-cycle expiry pulse. If auto-reload is set, it then copies the buffers again and keeps running. If auto-reload is clear, it stops and clears its own start bit, so software reading the control register sees the channel as idle.

The channel index is a parameter, and it fixes where the field sits in the control register. The highest channel has a reduced layout: it has no invert bit and no compare buffer, and its auto-reload bit is at a separate position.

Top module: `reload_timer_channel`

## Requirements
- R1: After reset, the live count, both buffers, the active compare value and the four field bits are 0, and the expiry output is low.
- R2: Channel 0 uses control bits [3:0], and channel n (n≥1) uses bits [4n+7:4n+4]. Inside the field, bit +0 is start, +1 is manual update, +2 is output invert and +3 is auto-reload. The field readback `fieldBits` is {auto-reload, invert, update, start}, with start at bit 0.
- R3: Channel 4 has start at bit 20, update at bit 21 and auto-reload at bit 22. It has no invert bit, so its `fieldBits[2]` always reads 0.
- R4: A write that takes the update bit from 0 to 1 loads the live count from the count buffer, and the active compare value from the compare buffer, at that clock edge. A write that leaves the update bit at 1 loads nothing.
- R5: While start is 1, each `tickEn` cycle with a nonzero count and no control write lowers the count by one. While start is 0, the count does not change except by a load.
- R6: A tick while running at count 0 with auto-reload 1 reloads the count and the compare value from the buffers, and start stays 1.
- R7: A tick while running at count 0 with auto-reload 0 leaves the count at 0 and clears the start bit in `fieldBits`.
- R8: `expiry` is high for exactly the cycle after the clock edge of an expiring tick, and is low otherwise.
- R9: Buffer writes do not change the live count or the active compare value until a load or reload. On channel 4, compare-buffer writes are ignored: `cmpBuf` and `activeCmp` read 0.
- R10: In a cycle with a control write, the tick is ignored. So when update and start rise in the same write, the buffer value is loaded before the first decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Count-enable strobe from the prescaler |
| ctrlWe | input | 1 | Write strobe for the shared control register |
| ctrlWdata | input | CTRL_W | Data written to the control register |
| cntBufWe | input | 1 | Write strobe for the count buffer |
| cmpBufWe | input | 1 | Write strobe for the compare buffer |
| bufWdata | input | COUNT_W | Data written to a buffer |
| fieldBits | output | 4 | This channel's control field {auto-reload, invert, update, start} |
| liveCount | output | COUNT_W | Current counter value |
| cntBuf | output | COUNT_W | Count buffer |
| cmpBuf | output | COUNT_W | Compare buffer |
| activeCmp | output | COUNT_W | Compare value in use |
| expiry | output | 1 | One-cycle expiry pulse |

## Verification
The bench targets four cases:
- **Update bit written twice at 1.** A channel that loaded on level rather than on edge would pick up a new buffer value on the second write.
- **Tick that arrives with an update-and-start write.** A channel that let the tick through would show one less than the buffer right after the write.
- **Expiry with auto-reload clear.** A design that left the start bit set would keep ticking. A design that wrapped the count would show all ones.
- **Channel 4 layout.** A design that kept the usual layout for channel 4 would treat bit 22 as invert and would never reload.

The bench also checks that buffer writes leave a running count alone, and runs a long random mix of ticks, writes and control changes against a cycle model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // One channel's slice of the shared control register
  typedef struct packed {
    logic autoReload;
    logic invert;
    logic update;
    logic start;
  } ctrlFieldT;

  // Strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic load;
    logic dec;
    logic reload;
    logic stop;
  } chanStrobeT;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int CH_IDX         = 0,
  parameter int CTRL_W         = 32,
  parameter int REDUCED_CH     = 4,
  parameter int ALT_RELOAD_POS = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              countZero,
  output ctrlFieldT         field,
  output chanStrobeT        strb
);

  localparam int  BASE       = (CH_IDX == 0) ? 0 : 4 * CH_IDX + 4;
  localparam bit  HAS_INV    = (CH_IDX != REDUCED_CH);
  localparam int  RELOAD_POS = HAS_INV ? BASE + 3 : ALT_RELOAD_POS;

  ctrlFieldT wrField;
  logic      active;
  logic      unusedCtrl;

  assign unusedCtrl = ^ctrlWdata;

  always_comb begin
    wrField.start      = ctrlWdata[BASE];
    wrField.update     = ctrlWdata[BASE+1];
    wrField.invert     = HAS_INV ? ctrlWdata[BASE+2] : 1'b0;
    wrField.autoReload = ctrlWdata[RELOAD_POS];
  end

  // A control write takes priority over a tick in the same cycle
  assign active = !ctrlWe && field.start && tickEn;

  always_comb begin
    strb.load   = ctrlWe && wrField.update && !field.update;
    strb.dec    = active && !countZero;
    strb.reload = active && countZero && field.autoReload;
    strb.stop   = active && countZero && !field.autoReload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field <= '0;
    end else if (ctrlWe) begin
      field <= wrField;
    end else if (strb.stop) begin
      field.start <= 1'b0;
    end
  end

  // R7: an expiry without auto-reload leaves the channel idle
  a_r7_stop_clears_start: assert property (@(posedge clk) disable iff (rst)
    strb.stop |=> !field.start);

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cntBufWe,
  input  logic               cmpBufWe,
  input  logic [COUNT_W-1:0] bufWdata,
  input  chanStrobeT         strb,
  output logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] cntBuf,
  output logic [COUNT_W-1:0] cmpBuf,
  output logic [COUNT_W-1:0] activeCmp,
  output logic               expiry,
  output logic               countZero
);

  logic takeBuf;
  logic unusedCmpWe;

  assign takeBuf     = strb.load || strb.reload;
  assign countZero   = (count == '0);
  assign unusedCmpWe = cmpBufWe;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntBuf <= '0;
      count  <= '0;
      expiry <= 1'b0;
    end else begin
      if (cntBufWe) cntBuf <= bufWdata;
      if (takeBuf) count <= cntBuf;
      else if (strb.dec) count <= count - 1'b1;
      expiry <= strb.reload || strb.stop;
    end
  end

  generate
    if (HAS_CMP) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst) begin
          cmpBuf    <= '0;
          activeCmp <= '0;
        end else begin
          if (cmpBufWe) cmpBuf <= bufWdata;
          if (takeBuf) activeCmp <= cmpBuf;
        end
      end
    end else begin : g_no_cmp
      assign cmpBuf    = '0;
      assign activeCmp = '0;
    end
  endgenerate

  // R4 / R6: a load or reload takes the buffer value as it stood before the edge
  a_r4_load_from_buffer: assert property (@(posedge clk) disable iff (rst)
    (strb.load || strb.reload) |=> (count == $past(cntBuf)));

endmodule

// File: rtl/reload_timer_channel.sv
module reload_timer_channel
  import rtc_pkg::*;
#(
  parameter int CH_IDX         = 0,
  parameter int COUNT_W        = 32,
  parameter int CTRL_W         = 32,
  parameter int REDUCED_CH     = 4,
  parameter int ALT_RELOAD_POS = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               ctrlWe,
  input  logic [CTRL_W-1:0]  ctrlWdata,
  input  logic               cntBufWe,
  input  logic               cmpBufWe,
  input  logic [COUNT_W-1:0] bufWdata,
  output logic [3:0]         fieldBits,
  output logic [COUNT_W-1:0] liveCount,
  output logic [COUNT_W-1:0] cntBuf,
  output logic [COUNT_W-1:0] cmpBuf,
  output logic [COUNT_W-1:0] activeCmp,
  output logic               expiry
);

  localparam bit HAS_CMP = (CH_IDX != REDUCED_CH);

  ctrlFieldT  field;
  chanStrobeT strb;
  logic       countZero;

  rtc_ctrl #(
    .CH_IDX(CH_IDX), .CTRL_W(CTRL_W),
    .REDUCED_CH(REDUCED_CH), .ALT_RELOAD_POS(ALT_RELOAD_POS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .ctrlWe(ctrlWe),
    .ctrlWdata(ctrlWdata), .countZero(countZero),
    .field(field), .strb(strb)
  );

  rtc_datapath #(.COUNT_W(COUNT_W), .HAS_CMP(HAS_CMP)) dp_i (
    .clk(clk), .rst(rst), .cntBufWe(cntBufWe), .cmpBufWe(cmpBufWe),
    .bufWdata(bufWdata), .strb(strb), .count(liveCount),
    .cntBuf(cntBuf), .cmpBuf(cmpBuf), .activeCmp(activeCmp),
    .expiry(expiry), .countZero(countZero)
  );

  assign fieldBits = field;

  // R5: a running tick with a nonzero count lowers the count by one
  a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
    (fieldBits[0] && tickEn && !ctrlWe && liveCount != '0)
      |=> (liveCount == $past(liveCount) - 1'b1));

  // R5: an idle channel holds its count unless loaded
  a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (!fieldBits[0] && !strb.load) |=> $stable(liveCount));

  // R8: a running tick at zero raises expiry on the next cycle
  a_r8_expiry_pulse: assert property (@(posedge clk) disable iff (rst)
    (fieldBits[0] && tickEn && !ctrlWe && liveCount == '0) |=> expiry);

endmodule

// File: tb/reload_timer_channel_tb_top.sv
`timescale 1ns/1ps
module reload_timer_channel_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tickEn = 1'b0;
  logic          ctrlWe = 1'b0;
  logic [31:0]   ctrlWdata = '0;
  logic          cntBufWe = 1'b0;
  logic          cmpBufWe = 1'b0;
  logic [CW-1:0] bufWdata = '0;

  logic [3:0]    fb1, fb4;
  logic [CW-1:0] cnt1, cb1, mb1, ac1, cnt4, cb4, mb4, ac4;
  logic          exp1, exp4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  reload_timer_channel #(.CH_IDX(1), .COUNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cntBufWe(cntBufWe), .cmpBufWe(cmpBufWe), .bufWdata(bufWdata),
    .fieldBits(fb1), .liveCount(cnt1), .cntBuf(cb1), .cmpBuf(mb1),
    .activeCmp(ac1), .expiry(exp1));

  reload_timer_channel #(.CH_IDX(4), .COUNT_W(CW)) dut_ch4_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cntBufWe(cntBufWe), .cmpBufWe(cmpBufWe), .bufWdata(bufWdata),
    .fieldBits(fb4), .liveCount(cnt4), .cntBuf(cb4), .cmpBuf(mb4),
    .activeCmp(ac4), .expiry(exp4));

  // Cycle model of channel 1: field at bits 8 (start), 9 (update), 10 (invert), 11 (reload)
  logic          mStart, mUpd, mInv, mRel, mExp;
  logic [CW-1:0] mCnt, mCntBuf, mCmpBuf, mCmp;

  always @(posedge clk) begin
    if (rst) begin
      {mStart, mUpd, mInv, mRel, mExp} <= '0;
      mCnt <= '0; mCntBuf <= '0; mCmpBuf <= '0; mCmp <= '0;
    end else begin
      mExp <= 1'b0;
      if (cntBufWe) mCntBuf <= bufWdata;
      if (cmpBufWe) mCmpBuf <= bufWdata;
      if (ctrlWe) begin
        if (ctrlWdata[9] && !mUpd) begin
          mCnt <= mCntBuf;
          mCmp <= mCmpBuf;
        end
        {mRel, mInv, mUpd, mStart} <= ctrlWdata[11:8];
      end else if (mStart && tickEn) begin
        if (mCnt == 0) begin
          mExp <= 1'b1;
          if (mRel) begin
            mCnt <= mCntBuf;
            mCmp <= mCmpBuf;
          end else begin
            mStart <= 1'b0;
          end
        end else begin
          mCnt <= mCnt - 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint expv);
    check(act == expv, tag, act, expv);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [31:0] d);
    ctrlWe = 1'b1; ctrlWdata = d;
    cyc();
    ctrlWe = 1'b0;
  endtask

  task automatic wrBufs(input bit doCnt, input bit doCmp, input logic [CW-1:0] d);
    cntBufWe = doCnt; cmpBufWe = doCmp; bufWdata = d;
    cyc();
    cntBufWe = 1'b0; cmpBufWe = 1'b0;
  endtask

  task automatic modelCompare(input string tag);
    check({fb1, cnt1, ac1, exp1} == {mRel, mInv, mUpd, mStart, mCnt, mCmp, mExp}, tag,
          {fb1, cnt1, ac1, exp1}, {mRel, mInv, mUpd, mStart, mCnt, mCmp, mExp});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 count", cnt1, 0); chk("R1 field", fb1, 0); chk("R1 expiry", exp1, 0);
    chk("R1 cntBuf", cb1, 0); chk("R1 cmpBuf", mb1, 0); chk("R1 activeCmp", ac1, 0);

    // R4 load on update rise, R2 field placement
    wrBufs(1, 0, 16'd3);
    wrBufs(0, 1, 16'd7);
    wrCtrl(32'h0000_0200);
    chk("R4 load count", cnt1, 3); chk("R4 load compare", ac1, 7);
    chk("R2 update bit 9", fb1, 4'b0010);

    // R4 level-held update loads nothing; R9 buffer write no effect; R2 invert bit 10
    wrBufs(1, 0, 16'd9);
    chk("R9 buffer write leaves count", cnt1, 3);
    wrCtrl(32'h0000_0600);
    chk("R4 no load while update held", cnt1, 3);
    chk("R2 invert bit 10", fb1, 4'b0110);

    // R5 counting, R6 reload, R8 pulse
    wrCtrl(32'h0000_0900);
    chk("R2 start bit 8 reload bit 11", fb1, 4'b1001);
    tickEn = 1'b1;
    cyc(); chk("R5 decrement", cnt1, 2);
    cyc(); chk("R5 decrement", cnt1, 1);
    cyc(); chk("R5 decrement", cnt1, 0); chk("R8 no expiry before zero tick", exp1, 0);
    cyc(); chk("R6 reload value", cnt1, 9); chk("R8 expiry high", exp1, 1);
    chk("R6 start kept", fb1[0], 1);
    tickEn = 1'b0;
    cyc(); chk("R8 expiry one cycle", exp1, 0); chk("R5 halted without tick", cnt1, 9);

    // R7 expiry without reload
    wrBufs(1, 0, 16'd1);
    chk("R9 buffer write while running", cnt1, 9);
    wrCtrl(32'h0000_0200);
    chk("R4 reload to 1", cnt1, 1);
    wrCtrl(32'h0000_0100);
    tickEn = 1'b1;
    cyc(); chk("R5 to zero", cnt1, 0);
    cyc(); chk("R7 start cleared", fb1, 4'b0000); chk("R7 count stays zero", cnt1, 0);
    chk("R8 expiry on stop", exp1, 1);
    cyc(); chk("R7 halted after stop", cnt1, 0); chk("R8 no repeat pulse", exp1, 0);

    // R10 update and start together with a tick present
    wrBufs(1, 0, 16'd4);
    wrCtrl(32'h0000_0300);
    chk("R10 load before first decrement", cnt1, 4);
    cyc(); chk("R10 first decrement", cnt1, 3);
    wrCtrl(32'h0000_0000);
    chk("R5 start fall halts", cnt1, 3);
    cyc(); chk("R5 halted ignores tick", cnt1, 3);
    tickEn = 1'b0;

    // R3 / R9 channel 4 layout
    wrBufs(1, 1, 16'd2);
    wrCtrl(32'h0060_0000);
    chk("R3 ch4 update+reload", fb4, 4'b1010); chk("R3 ch4 load", cnt4, 2);
    chk("R9 ch4 compare buffer ignored", mb4, 0); chk("R9 ch4 active compare", ac4, 0);
    wrCtrl(32'h0050_0000);
    chk("R3 ch4 start+reload", fb4, 4'b1001);
    tickEn = 1'b1;
    cyc(); cyc(); cyc();
    chk("R3 ch4 reload at bit 22", cnt4, 2); chk("R3 ch4 expiry", exp4, 1);
    chk("R3 ch4 still running", fb4[0], 1);
    tickEn = 1'b0;
    wrCtrl(32'h0010_0000);
    chk("R3 ch4 no invert bit", fb4, 4'b0001);

    // Random mix compared against the cycle model: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      tickEn   = ($urandom % 3) != 0;
      ctrlWe   = ($urandom % 8) == 0;
      ctrlWdata = $urandom;
      cntBufWe = ($urandom % 6) == 0;
      cmpBufWe = ($urandom % 6) == 0;
      bufWdata = CW'($urandom % 6);
      cyc();
      modelCompare("R5 R6 R7 R8 R9 R10 random");
    end
    ctrlWe = 1'b0; cntBufWe = 1'b0; cmpBufWe = 1'b0; tickEn = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule